// File: doc/BRIEF.md
# Card Power-Down Controller

This block governs the low-power state of a set of flash device pairs on a memory card. A host writes two small registers through a simple write/read port. The first holds a card-wide power-down bit. The second holds one sleep bit per device pair. From these two registers the block drives one deep-sleep line per pair. When a pair leaves deep sleep, a per-pair counter runs a fixed recovery interval. Only after that interval does the pair's ready flag rise.

Host accesses aimed at a pair go through an access gate. An access to a ready pair is forwarded as a one-hot select. An access to a pair that is sleeping or still recovering is refused with an error flag. The block also flags the card's standby condition. Standby means exactly one pair is awake, recovered and in read-array mode, every other pair is asleep, and both active-low chip enables are high.

Top module: `cpd_ctrl`

## Requirements
- R1: After reset the power-down bit is 1 and all sleep bits are 1. Every `deep_sleep` bit is high, every `pair_ready` bit is low, the global register reads 1 and the sleep register reads all ones.
- R2: A write of 1 to bit 0 of the global register (`reg_sel`=0) drives every `deep_sleep` bit high from the next cycle, whatever the sleep bits hold.
- R3: `deep_sleep[i]` is low exactly when the power-down bit is 0 and bit i of the sleep register (`reg_sel`=1) is 0. Sleep bits written while power-down is set are stored, and they take effect once power-down is cleared.
- R4: After `deep_sleep[i]` falls, `pair_ready[i]` stays low for exactly RECOVER_CYC cycles and then rises.
- R5: `pair_ready[i]` is never high while `deep_sleep[i]` is high.
- R6: A write that puts pair i to sleep drops `pair_ready[i]` in the same cycle that `deep_sleep[i]` rises.
- R7: When `acc_req` is high and the pair chosen by `acc_pair` is ready, `acc_fwd` has exactly that pair's bit set and `acc_err` is low, in the same cycle.
- R8: When `acc_req` is high and the chosen pair is asleep or still recovering, `acc_err` is high and `acc_fwd` is zero. With no request, both are zero.
- R9: `reg_rdata` gives the last written value of the register chosen by `reg_sel`. The global register keeps only bit 0, and its upper bits read as 0.
- R10: `standby` is high exactly when all of these hold: one pair is awake, that pair is ready, its `array_mode` bit is set, and `ce1_n` and `ce2_n` are both high.
- R11: A register write takes effect at the clock edge that samples it. An access in that same cycle is judged on the state before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 global power-down, 1 per-pair sleep |
| reg_wdata | input | NUM_PAIRS | Write data |
| reg_rdata | output | NUM_PAIRS | Read data of the selected register |
| acc_req | input | 1 | Host access request |
| acc_pair | input | PAIR_W | Target pair of the access |
| acc_fwd | output | NUM_PAIRS | One-hot forwarded access |
| acc_err | output | 1 | Access refused |
| array_mode | input | NUM_PAIRS | Pair is in read-array mode |
| ce1_n | input | 1 | Chip enable 1, active low |
| ce2_n | input | 1 | Chip enable 2, active low |
| deep_sleep | output | NUM_PAIRS | Deep-sleep drive per pair |
| pair_ready | output | NUM_PAIRS | Pair recovered and usable |
| standby | output | 1 | Card is in standby |

## Verification
Two things can land in one cycle: a sleep-register write and a host access to the pair that the write puts to sleep. The bench raises both in the same cycle. Before the edge it expects the access to be forwarded, since the old state still holds. After the edge it expects the same request to be refused and the pair's ready flag to be down, with deep sleep driven.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
  typedef enum logic {SEL_GLOBAL = 1'b0, SEL_SLEEP = 1'b1} cpd_sel_e;

  // Next value of a recovery counter: reload while asleep, count down when awake.
  function automatic int unsigned wake_next(input int unsigned cur, input logic asleep,
                                            input int unsigned reload);
    if (asleep) return reload;
    else if (cur != 0) return cur - 1;
    else return 0;
  endfunction

  function automatic logic wake_done(input int unsigned cur, input logic asleep);
    return !asleep && (cur == 0);
  endfunction
endpackage

// File: rtl/cpd_regs.sv
module cpd_regs #(
  parameter int NUM_PAIRS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic                 sel,
  input  logic [NUM_PAIRS-1:0] wdata,
  output logic                 gpd,
  output logic [NUM_PAIRS-1:0] sleep_bits,
  output logic [NUM_PAIRS-1:0] rdata
);
  import cpd_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gpd        <= 1'b1;
      sleep_bits <= '1;
    end else if (wr) begin
      if (cpd_sel_e'(sel) == SEL_GLOBAL) gpd <= wdata[0];
      else                               sleep_bits <= wdata;
    end
  end

  always_comb begin
    if (cpd_sel_e'(sel) == SEL_GLOBAL) rdata = {{(NUM_PAIRS-1){1'b0}}, gpd};
    else                               rdata = sleep_bits;
  end
endmodule

// File: rtl/cpd_wake_timer.sv
module cpd_wake_timer #(
  parameter int unsigned RECOVER_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic asleep,
  output logic ready
);
  import cpd_pkg::*;
  localparam int CW = (RECOVER_CYC < 1) ? 1 : $clog2(RECOVER_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CW'(RECOVER_CYC);
    else        cnt_q <= CW'(wake_next(32'(cnt_q), asleep, RECOVER_CYC));
  end

  assign ready = wake_done(32'(cnt_q), asleep);
endmodule

// File: rtl/cpd_access_gate.sv
module cpd_access_gate #(
  parameter int NUM_PAIRS = 4,
  localparam int PAIR_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
  input  logic                 req,
  input  logic [PAIR_W-1:0]    pair,
  input  logic [NUM_PAIRS-1:0] ready,
  output logic [NUM_PAIRS-1:0] fwd,
  output logic                 err
);
  logic hit_ready;

  always_comb begin
    hit_ready = 1'b0;
    for (int i = 0; i < NUM_PAIRS; i++)
      if (pair == PAIR_W'(i)) hit_ready = ready[i];
  end

  always_comb begin
    fwd = '0;
    err = 1'b0;
    if (req) begin
      if (hit_ready) begin
        for (int i = 0; i < NUM_PAIRS; i++)
          if (pair == PAIR_W'(i)) fwd[i] = 1'b1;
      end else begin
        err = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cpd_ctrl.sv
module cpd_ctrl #(
  parameter int          NUM_PAIRS   = 4,
  parameter int unsigned RECOVER_CYC = 16,
  localparam int PAIR_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_sel,
  input  logic [NUM_PAIRS-1:0] reg_wdata,
  output logic [NUM_PAIRS-1:0] reg_rdata,
  input  logic                 acc_req,
  input  logic [PAIR_W-1:0]    acc_pair,
  output logic [NUM_PAIRS-1:0] acc_fwd,
  output logic                 acc_err,
  input  logic [NUM_PAIRS-1:0] array_mode,
  input  logic                 ce1_n,
  input  logic                 ce2_n,
  output logic [NUM_PAIRS-1:0] deep_sleep,
  output logic [NUM_PAIRS-1:0] pair_ready,
  output logic                 standby
);
  logic                 gpd;
  logic [NUM_PAIRS-1:0] sleep_bits;
  logic [NUM_PAIRS-1:0] awake_vec;
  logic                 one_awake;
  logic                 awake_usable;

  cpd_regs #(.NUM_PAIRS(NUM_PAIRS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .gpd(gpd), .sleep_bits(sleep_bits), .rdata(reg_rdata)
  );

  assign deep_sleep = sleep_bits | {NUM_PAIRS{gpd}};
  assign awake_vec  = ~deep_sleep;

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    cpd_wake_timer #(.RECOVER_CYC(RECOVER_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .asleep(deep_sleep[g]), .ready(pair_ready[g])
    );
  end

  cpd_access_gate #(.NUM_PAIRS(NUM_PAIRS)) u_gate (
    .req(acc_req), .pair(acc_pair), .ready(pair_ready), .fwd(acc_fwd), .err(acc_err)
  );

  assign one_awake    = ($countones(awake_vec) == 1);
  assign awake_usable = ((awake_vec & ~(pair_ready & array_mode)) == '0);
  assign standby      = ce1_n & ce2_n & one_awake & awake_usable;
endmodule

// File: rtl/cpd_ctrl_chk.sv
module cpd_ctrl_chk #(
  parameter int          NUM_PAIRS   = 4,
  parameter int unsigned RECOVER_CYC = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr,
  input logic                 reg_sel,
  input logic [NUM_PAIRS-1:0] reg_wdata,
  input logic                 acc_req,
  input logic [NUM_PAIRS-1:0] acc_fwd,
  input logic                 acc_err,
  input logic                 ce1_n,
  input logic                 ce2_n,
  input logic [NUM_PAIRS-1:0] deep_sleep,
  input logic [NUM_PAIRS-1:0] pair_ready,
  input logic                 standby
);
  p_gpd_sleep_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 1'b0 && reg_wdata[0]) |=> (&deep_sleep));

  p_sleep_drops_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 1'b1) |=> ((pair_ready & $past(reg_wdata)) == '0));

  p_fwd_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc_fwd) && ((acc_fwd & ~pair_ready) == '0));

  p_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req |-> (acc_err != (|acc_fwd)));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_req |-> (!acc_err && acc_fwd == '0));

  p_standby_r10: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> (ce1_n && ce2_n && $countones(~deep_sleep) == 1));

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_chk
    int unsigned awake_len;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       awake_len <= 0;
      else if (deep_sleep[g])           awake_len <= 0;
      else if (awake_len <= RECOVER_CYC) awake_len <= awake_len + 1;
    end

    p_ready_awake_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pair_ready[g] |-> !deep_sleep[g]);

    p_recover_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pair_ready[g]) |-> (awake_len == RECOVER_CYC));
  end
endmodule

bind cpd_ctrl cpd_ctrl_chk #(.NUM_PAIRS(NUM_PAIRS), .RECOVER_CYC(RECOVER_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .acc_req(acc_req), .acc_fwd(acc_fwd), .acc_err(acc_err), .ce1_n(ce1_n), .ce2_n(ce2_n),
  .deep_sleep(deep_sleep), .pair_ready(pair_ready), .standby(standby)
);

// File: tb/tb_cpd_ctrl.sv
`timescale 1ns/1ps
module tb_cpd_ctrl;
  localparam int N = 4;
  localparam int R = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic reg_sel = 1'b0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;
  logic acc_req = 1'b0;
  logic [1:0] acc_pair = '0;
  logic [N-1:0] acc_fwd;
  logic acc_err;
  logic [N-1:0] array_mode = '0;
  logic ce1_n = 1'b1;
  logic ce2_n = 1'b1;
  logic [N-1:0] deep_sleep;
  logic [N-1:0] pair_ready;
  logic standby;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  cpd_ctrl #(.NUM_PAIRS(N), .RECOVER_CYC(R)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .acc_req(acc_req), .acc_pair(acc_pair), .acc_fwd(acc_fwd),
    .acc_err(acc_err), .array_mode(array_mode), .ce1_n(ce1_n), .ce2_n(ce2_n),
    .deep_sleep(deep_sleep), .pair_ready(pair_ready), .standby(standby)
  );

  // {sel, wdata, expected rdata, expected deep_sleep}
  localparam logic [12:0] VEC [8] = '{
    {1'b1, 4'hA, 4'hA, 4'hF},   // R3: stored while power-down set
    {1'b0, 4'h0, 4'h0, 4'hA},   // R3: power-down cleared, sleep bits apply
    {1'b1, 4'h5, 4'h5, 4'h5},
    {1'b1, 4'hE, 4'hE, 4'hE},
    {1'b0, 4'hF, 4'h1, 4'hF},   // R9 / R2: only bit 0 kept
    {1'b0, 4'h2, 4'h0, 4'hE},   // R9: bit 0 is 0
    {1'b1, 4'h0, 4'h0, 4'h0},
    {1'b1, 4'hF, 4'hF, 4'hF}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [N-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 deep_sleep", 32'(deep_sleep), 32'hF);
    chk("R1 pair_ready", 32'(pair_ready), 32'h0);
    reg_sel = 1'b0; #1;
    chk("R1 global readback", 32'(reg_rdata), 32'h1);
    reg_sel = 1'b1; #1;
    chk("R1 sleep readback", 32'(reg_rdata), 32'hF);

    for (int v = 0; v < 8; v++) begin
      wr(VEC[v][12], VEC[v][11:8]);
      #1;
      chk($sformatf("R9 rdata vec%0d", v), 32'(reg_rdata), 32'(VEC[v][7:4]));
      chk($sformatf("R3 deep_sleep vec%0d", v), 32'(deep_sleep), 32'(VEC[v][3:0]));
    end

    // R4: pair 0 wakes, ready after exactly R cycles
    wr(1'b1, 4'hE);
    #1;
    chk("R3 deep_sleep wake0", 32'(deep_sleep), 32'hE);
    chk("R4 ready low at wake", 32'(pair_ready[0]), 32'h0);
    for (int k = 1; k <= R; k++) begin
      @(negedge clk); #1;
      chk($sformatf("R4 ready at cycle %0d", k), 32'(pair_ready[0]), 32'(k == R));
    end

    // R7 / R8: accesses
    acc_req = 1'b1; acc_pair = 2'd0; #1;
    chk("R7 fwd ready pair", 32'(acc_fwd), 32'h1);
    chk("R7 no err", 32'(acc_err), 32'h0);
    acc_pair = 2'd1; #1;
    chk("R8 asleep err", 32'(acc_err), 32'h1);
    chk("R8 asleep no fwd", 32'(acc_fwd), 32'h0);
    acc_req = 1'b0; #1;
    chk("R8 idle quiet", 32'({acc_err, acc_fwd}), 32'h0);
    wr(1'b1, 4'hC);
    acc_req = 1'b1; acc_pair = 2'd1; #1;
    chk("R8 recovering err", 32'(acc_err), 32'h1);
    chk("R5 recovering not ready", 32'(pair_ready), 32'h1);
    acc_req = 1'b0;

    // R10: standby
    array_mode = 4'hF;
    repeat (R + 1) @(negedge clk);
    #1;
    chk("R10 two awake no standby", 32'(standby), 32'h0);
    wr(1'b1, 4'hE);
    #1;
    chk("R6 ready drops with sleep", 32'(pair_ready), 32'h1);
    chk("R10 standby", 32'(standby), 32'h1);
    ce1_n = 1'b0; #1;
    chk("R10 ce1 low", 32'(standby), 32'h0);
    ce1_n = 1'b1; ce2_n = 1'b0; #1;
    chk("R10 ce2 low", 32'(standby), 32'h0);
    ce2_n = 1'b1; array_mode = 4'hE; #1;
    chk("R10 not array mode", 32'(standby), 32'h0);
    array_mode = 4'h1;

    // R11: sleep write and access in the same cycle
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 4'hF;
    acc_req = 1'b1; acc_pair = 2'd0;
    #1;
    chk("R11 access uses old state", 32'(acc_fwd), 32'h1);
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
    chk("R11 access refused after edge", 32'({acc_err, acc_fwd}), 32'h10);
    chk("R6 ready low after sleep", 32'(pair_ready), 32'h0);
    chk("R10 standby gone", 32'(standby), 32'h0);
    acc_req = 1'b0;

    // R2 / R3 / R4: global power-down over awake pairs
    wr(1'b1, 4'h0);
    repeat (R) @(negedge clk);
    #1;
    chk("R4 all ready", 32'(pair_ready), 32'hF);
    wr(1'b0, 4'h1);
    #1;
    chk("R2 all asleep", 32'(deep_sleep), 32'hF);
    chk("R5 none ready", 32'(pair_ready), 32'h0);
    wr(1'b0, 4'h0);
    #1;
    chk("R3 all awake", 32'(deep_sleep), 32'h0);
    chk("R4 recovering", 32'(pair_ready), 32'h0);
    repeat (R) @(negedge clk);
    #1;
    chk("R4 all ready again", 32'(pair_ready), 32'hF);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule